// File: doc/BRIEF.md
# Per-Port Priority-Aware Rate Limiter

This block polices the traffic of one switch port in both directions. The ingress path and the egress path each have two byte budgets, one for high-priority frames and one for low-priority frames. Each budget is a token bucket. A 12-bit step count sets the rate in steps of 32 kb/s, from zero up to 100 Mb/s. Every millisecond the bucket gains four bytes of credit per step, and every byte that passes through the port spends one byte of credit.

The MAC reports each frame with a start strobe, a valid pulse for every byte, and an end strobe. It also gives a priority bit, which the block samples at frame start. The block never cuts a frame that has already started: it decides whether a frame is over rate only at frame start. On ingress a mode input picks one of two responses to an over-rate frame. The block either raises a pause request for flow control, or flags the whole frame for dropping. On egress the block lowers a transmit-allow output until credit recovers, and the MAC holds its next frame back for that time.

Top module: `port_rate_policer`

## Requirements
- R1: The four buckets (ingress high, ingress low, egress high, egress low) are independent. The priority bit, where 1 means high, is sampled at frame start and chooses the bucket the frame's bytes are charged to. A low-priority budget is unaffected by high-priority traffic.
- R2: Once every CLK_PER_US × US_PER_MS clock cycles, each enabled bucket gains 4 × min(count, 3125) bytes of credit. Each byte-valid pulse of a frame that is charged spends one byte of credit.
- R3: A bucket's balance never exceeds MAX_FRAME plus one refill.
- R4: The over-rate decision is made only in the frame-start cycle, and a negative balance means over rate. The drop flag stays constant from the cycle after frame start through the frame-end cycle.
- R5: In drop mode (in_drop_mode_i = 1), an over-rate ingress frame raises in_drop_o from the cycle after its start until its end. The bytes of a dropped frame spend no credit.
- R6: In flow-control mode (in_drop_mode_i = 0), in_pause_o is high while either ingress balance is negative and falls once that balance is non-negative again. In this mode in_drop_o is never raised.
- R7: eg_allow_o is low while the egress bucket chosen by eg_hi_i has a negative balance, and high otherwise.
- R8: A count of zero disables a bucket. Its traffic is then unlimited: no pause, no drop and no hold-off.
- R9: Under a constant offered load above the programmed rate, the bytes accepted over a 100 ms window differ from the programmed credit by no more than two frames plus one refill, for each direction and priority.
- R10: After reset every balance is zero, in_pause_o and in_drop_o are low and eg_allow_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_rate_hi_i | input | 12 | Ingress high-priority rate, in 32 kb/s steps |
| in_rate_lo_i | input | 12 | Ingress low-priority rate, in 32 kb/s steps |
| eg_rate_hi_i | input | 12 | Egress high-priority rate, in 32 kb/s steps |
| eg_rate_lo_i | input | 12 | Egress low-priority rate, in 32 kb/s steps |
| in_drop_mode_i | input | 1 | 1 selects drop, 0 selects flow control for ingress |
| in_sof_i | input | 1 | Ingress frame start strobe |
| in_eof_i | input | 1 | Ingress frame end strobe |
| in_byte_i | input | 1 | Ingress byte valid |
| in_hi_i | input | 1 | Ingress frame priority, sampled at start |
| in_pause_o | output | 1 | Flow-control pause request |
| in_drop_o | output | 1 | Current ingress frame is to be dropped |
| eg_sof_i | input | 1 | Egress frame start strobe |
| eg_eof_i | input | 1 | Egress frame end strobe |
| eg_byte_i | input | 1 | Egress byte valid |
| eg_hi_i | input | 1 | Priority of the pending or started egress frame |
| eg_allow_o | output | 1 | Next egress frame may start |

## Verification
The bench builds the block with CLK_PER_US = 4, US_PER_MS = 25 and MAX_FRAME = 64. With these values a refill arrives every 100 cycles, and a 100 ms throughput window lasts 10,000 cycles. At one byte per cycle the line carries 100 bytes per refill, so step counts of 3 to 10 are clearly over-subscribed. Each direction and priority can therefore be pushed into steady limiting, and the cap, the refill and the drop-versus-pause choice can be compared exactly against arithmetic in the bench.

// File: rtl/rate_pkg.sv
package rate_pkg;
  localparam int RATE_W   = 12;
  localparam int RATE_SAT = 3125;  // 100 Mb/s in 32 kb/s steps
  localparam int STEP_B   = 4;     // bytes per step per millisecond

  function automatic logic [RATE_W-1:0] sat_rate(input logic [RATE_W-1:0] r);
    return (r > RATE_W'(RATE_SAT)) ? RATE_W'(RATE_SAT) : r;
  endfunction
endpackage

// File: rtl/rate_tick_gen.sv
module rate_tick_gen #(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int UW = $clog2(CLK_PER_US + 1);
  localparam int MW = $clog2(US_PER_MS + 1);

  logic [UW-1:0] us_q;
  logic [MW-1:0] ms_q;
  logic us_wrap, ms_wrap;

  assign us_wrap = (us_q == UW'(CLK_PER_US - 1));
  assign ms_wrap = (ms_q == MW'(US_PER_MS - 1));
  assign tick_o  = us_wrap && ms_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q <= '0;
      ms_q <= '0;
    end else begin
      us_q <= us_wrap ? '0 : us_q + 1'b1;
      if (us_wrap) ms_q <= ms_wrap ? '0 : ms_q + 1'b1;
    end
  end
endmodule

// File: rtl/rate_bucket.sv
module rate_bucket
  import rate_pkg::*;
#(
  parameter int MAX_FRAME = 1522
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              take_i,
  output logic              over_o
);
  localparam int BAL_W = $clog2(MAX_FRAME + RATE_SAT * STEP_B + 1) + 2;

  logic signed [BAL_W-1:0] bal_q, bal_d, credit_s, cap_s, sum_s;
  logic                    enabled;

  assign enabled  = (rate_i != '0);
  assign credit_s = signed'({{(BAL_W-RATE_W){1'b0}}, sat_rate(rate_i)} << 2);
  assign cap_s    = signed'(BAL_W'(MAX_FRAME)) + credit_s;

  always_comb begin
    sum_s = bal_q;
    if (tick_i) sum_s = sum_s + credit_s;
    if (take_i) sum_s = sum_s - BAL_W'(1);
    bal_d = (sum_s > cap_s) ? cap_s : sum_s;
    if (!enabled) bal_d = '0;   // disabled bucket idles at zero
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bal_q <= '0;
    else         bal_q <= bal_d;
  end

  assign over_o = bal_q[BAL_W-1];

  a_r3_cap_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i != '0) |=> (bal_q <= $past(cap_s)));

  a_r2_refill_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !take_i && enabled && bal_q <= cap_s) |=> (bal_q >= $past(bal_q)));
endmodule

// File: rtl/dir_policer.sv
module dir_policer
  import rate_pkg::*;
#(
  parameter int MAX_FRAME = 1522
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_hi_i,
  input  logic [RATE_W-1:0] rate_lo_i,
  input  logic              drop_mode_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              byte_i,
  input  logic              hi_i,
  output logic              over_hi_o,
  output logic              over_lo_o,
  output logic              drop_o
);
  logic active_q, prio_q, drop_q;
  logic [1:0] over, take;
  logic [1:0][RATE_W-1:0] rates;

  assign rates = {rate_hi_i, rate_lo_i};   // index 1 = high priority

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      prio_q   <= 1'b0;
      drop_q   <= 1'b0;
    end else if (sof_i) begin
      active_q <= 1'b1;
      prio_q   <= hi_i;
      drop_q   <= drop_mode_i && over[hi_i];
    end else if (eof_i) begin
      active_q <= 1'b0;
      drop_q   <= 1'b0;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_bucket
    assign take[g] = byte_i && active_q && (prio_q == 1'(g)) && !drop_q;
    rate_bucket #(.MAX_FRAME(MAX_FRAME)) u_bucket (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .rate_i(rates[g]),
      .take_i(take[g]),
      .over_o(over[g])
    );
  end

  assign over_hi_o = over[1];
  assign over_lo_o = over[0];
  assign drop_o    = drop_q;

  a_r4_drop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !sof_i && !eof_i) |=> $stable(drop_q));

  a_r5_drop_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drop_q) |-> $past(sof_i && drop_mode_i && over[hi_i]));
endmodule

// File: rtl/port_rate_policer.sv
module port_rate_policer
  import rate_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000,
  parameter int MAX_FRAME  = 1522
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] in_rate_hi_i,
  input  logic [RATE_W-1:0] in_rate_lo_i,
  input  logic [RATE_W-1:0] eg_rate_hi_i,
  input  logic [RATE_W-1:0] eg_rate_lo_i,
  input  logic              in_drop_mode_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic              in_byte_i,
  input  logic              in_hi_i,
  output logic              in_pause_o,
  output logic              in_drop_o,
  input  logic              eg_sof_i,
  input  logic              eg_eof_i,
  input  logic              eg_byte_i,
  input  logic              eg_hi_i,
  output logic              eg_allow_o
);
  logic tick;
  logic in_over_hi, in_over_lo, eg_over_hi, eg_over_lo, eg_drop;

  rate_tick_gen #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  dir_policer #(.MAX_FRAME(MAX_FRAME)) u_ingress (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .rate_hi_i  (in_rate_hi_i),
    .rate_lo_i  (in_rate_lo_i),
    .drop_mode_i(in_drop_mode_i),
    .sof_i      (in_sof_i),
    .eof_i      (in_eof_i),
    .byte_i     (in_byte_i),
    .hi_i       (in_hi_i),
    .over_hi_o  (in_over_hi),
    .over_lo_o  (in_over_lo),
    .drop_o     (in_drop_o)
  );

  dir_policer #(.MAX_FRAME(MAX_FRAME)) u_egress (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .rate_hi_i  (eg_rate_hi_i),
    .rate_lo_i  (eg_rate_lo_i),
    .drop_mode_i(1'b0),
    .sof_i      (eg_sof_i),
    .eof_i      (eg_eof_i),
    .byte_i     (eg_byte_i),
    .hi_i       (eg_hi_i),
    .over_hi_o  (eg_over_hi),
    .over_lo_o  (eg_over_lo),
    .drop_o     (eg_drop)
  );

  assign in_pause_o = !in_drop_mode_i && (in_over_hi || in_over_lo);
  assign eg_allow_o = !(eg_hi_i ? eg_over_hi : eg_over_lo) && !eg_drop;

  a_r6_pause_not_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_drop_mode_i && $past(!in_drop_mode_i) && in_sof_i) |=> !in_drop_o);
endmodule

// File: tb/port_rate_policer_tb.sv
module port_rate_policer_tb;
  localparam int CPU = 4;
  localparam int UPM = 25;
  localparam int MF  = 64;
  localparam int TICK = CPU * UPM;  // cycles per refill
  localparam int F   = 32;          // bench frame length in bytes

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [11:0] in_rate_hi_i = '0, in_rate_lo_i = '0, eg_rate_hi_i = '0, eg_rate_lo_i = '0;
  logic in_drop_mode_i = 1'b0;
  logic in_sof_i = 1'b0, in_eof_i = 1'b0, in_byte_i = 1'b0, in_hi_i = 1'b0;
  logic eg_sof_i = 1'b0, eg_eof_i = 1'b0, eg_byte_i = 1'b0, eg_hi_i = 1'b0;
  logic in_pause_o, in_drop_o, eg_allow_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  port_rate_policer #(.CLK_PER_US(CPU), .US_PER_MS(UPM), .MAX_FRAME(MF)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    in_sof_i = 0; in_eof_i = 0; in_byte_i = 0;
    eg_sof_i = 0; eg_eof_i = 0; eg_byte_i = 0;
  endtask

  // Constant offered load: back-to-back frames, each start gated by the block's response.
  task automatic run_stream(input bit ing, input bit hi, input int warm, input int meas,
                            output int acc, output int drops, output int blocked,
                            output int pause_seen, output int unstable, output int flow_drops);
    int pos = -1;
    bit dfirst = 0;
    bit permit;
    acc = 0; drops = 0; blocked = 0; pause_seen = 0; unstable = 0; flow_drops = 0;
    in_hi_i = hi; eg_hi_i = hi;
    for (int c = 0; c < warm + meas; c++) begin
      @(negedge clk_i);
      if (in_pause_o) pause_seen++;
      clear_strobes();
      if (pos < 0) begin
        permit = ing ? (in_drop_mode_i || !in_pause_o) : eg_allow_o;
        if (!permit) blocked++;
        else begin
          if (ing) in_sof_i = 1; else eg_sof_i = 1;
          pos = 0;
        end
      end else begin
        if (pos == 0) begin
          dfirst = ing ? in_drop_o : 1'b0;
          if (ing && !in_drop_mode_i && dfirst) flow_drops++;
          if (c >= warm) begin
            if (dfirst) drops++; else acc += F;
          end
        end
        if (ing && in_drop_o != dfirst) unstable++;
        if (ing) begin in_byte_i = 1; in_eof_i = (pos == F-1); end
        else     begin eg_byte_i = 1; eg_eof_i = (pos == F-1); end
        pos = (pos == F-1) ? -1 : pos + 1;
      end
    end
    @(negedge clk_i);
    clear_strobes();
  endtask

  task automatic eg_frame();
    eg_sof_i = 1;
    for (int i = 0; i < F; i++) begin
      @(negedge clk_i);
      eg_sof_i = 0; eg_byte_i = 1; eg_eof_i = (i == F-1);
    end
    @(negedge clk_i);
    eg_byte_i = 0; eg_eof_i = 0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish_sim();
  end

  initial begin
    int acc, drops, blocked, pseen, unst, fdrop, exp, tol, n, gap;
    bit got_block;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R10: reset state
    check(in_pause_o == 0, "R10 pause after reset", in_pause_o, 0);
    check(in_drop_o == 0, "R10 drop after reset", in_drop_o, 0);
    check(eg_allow_o == 1, "R10 allow after reset", eg_allow_o, 1);

    // R8: all rates zero -> unlimited in both directions
    in_drop_mode_i = 1;
    run_stream(1, 0, 0, 2000, acc, drops, blocked, pseen, unst, fdrop);
    check(drops == 0, "R8 ingress unlimited drops", drops, 0);
    run_stream(0, 1, 0, 2000, acc, drops, blocked, pseen, unst, fdrop);
    check(blocked == 0, "R8 egress unlimited holds", blocked, 0);

    // R9 R7 R2: egress high priority, count 10
    eg_rate_hi_i = 10;
    run_stream(0, 1, 1000, 10000, acc, drops, blocked, pseen, unst, fdrop);
    exp = (10000 / TICK) * 4 * 10; tol = 2*F + 4*10;
    gap = acc - exp;
    check(gap <= tol && gap >= -tol, "R9 R2 egress hi throughput", acc, exp);
    check(blocked > 0, "R7 egress hi held off", blocked, 1);
    // R1: hi exhausted, lo (disabled) still allowed
    got_block = 0;
    for (int k = 0; k < 40; k++) begin
      if (!eg_allow_o) begin got_block = 1; break; end
      eg_frame();
    end
    check(got_block, "R7 egress hi allow low when over", eg_allow_o, 0);
    eg_hi_i = 0; #1;
    check(eg_allow_o == 1, "R1 egress lo independent of hi", eg_allow_o, 1);
    eg_rate_hi_i = 0;

    // R9: egress low priority, count 3
    eg_rate_lo_i = 3;
    run_stream(0, 0, 1000, 10000, acc, drops, blocked, pseen, unst, fdrop);
    exp = (10000 / TICK) * 4 * 3; tol = 2*F + 4*3;
    gap = acc - exp;
    check(gap <= tol && gap >= -tol, "R9 egress lo throughput", acc, exp);
    // R3: after long idle balance sits at cap = 64 + 12 -> exactly 3 frames pass
    repeat (20 * TICK) @(negedge clk_i);
    eg_hi_i = 0; n = 0;
    for (int k = 0; k < 20; k++) begin
      if (!eg_allow_o) break;
      eg_frame(); n++;
    end
    check(n == 3, "R3 burst limited by cap", n, 3);
    eg_rate_lo_i = 0;

    // R6 R9: ingress flow control, high priority, count 7
    in_drop_mode_i = 0; in_rate_hi_i = 7;
    run_stream(1, 1, 1000, 10000, acc, drops, blocked, pseen, unst, fdrop);
    exp = (10000 / TICK) * 4 * 7; tol = 2*F + 4*7;
    gap = acc - exp;
    check(gap <= tol && gap >= -tol, "R9 ingress hi flow throughput", acc, exp);
    check(pseen > 0, "R6 pause raised when over", pseen, 1);
    check(fdrop == 0, "R6 no drop in flow mode", fdrop, 0);
    n = -1;
    for (int k = 0; k < 3 * TICK; k++) begin
      @(negedge clk_i);
      if (!in_pause_o) begin n = k; break; end
    end
    check(n >= 0, "R6 pause released after refill", in_pause_o, 0);
    in_rate_hi_i = 0;

    // R5 R4 R9: ingress drop mode, low priority, count 5
    in_drop_mode_i = 1; in_rate_lo_i = 5;
    run_stream(1, 0, 1000, 10000, acc, drops, blocked, pseen, unst, fdrop);
    exp = (10000 / TICK) * 4 * 5; tol = 2*F + 4*5;
    gap = acc - exp;
    check(gap <= tol && gap >= -tol, "R9 R5 ingress lo accepted bytes", acc, exp);
    check(drops > 0, "R5 over-rate frames dropped", drops, 1);
    check(unst == 0, "R4 drop flag constant in frame", unst, 0);
    check(pseen == 0, "R5 no pause in drop mode", pseen, 0);
    // R1: high-priority ingress unaffected while low bucket is drained
    run_stream(1, 1, 0, 500, acc, drops, blocked, pseen, unst, fdrop);
    check(drops == 0, "R1 ingress hi independent of lo", drops, 0);
    in_rate_lo_i = 0;

    finish_sim();
  end
endmodule